// File: doc/BRIEF.md
# Privileged Control Register File

This block holds a small set of 64-bit privileged processor control registers behind one combinational read port and one clocked write port. Both ports select a register by a 5-bit index. Several indices carry side effects.

- **Soft-interrupt word.** It can be written whole. Two alias indices OR bits into it or knock bits out of it.
- **Trap base register.** It never holds its low fifteen bits.
- **Hypervisor state word.** It always has its bit 11 set after a write.
- **Version word.** It is read-only. It is built from configuration parameters.
- **Interrupt queue pointers.** There are eight: a head and a tail for each of four queues. Writing any of them requests a fresh interrupt evaluation through a one-cycle strobe.

An access to an index outside the map, or a write to the version word, raises an error output in the same cycle. Such a write changes nothing.

The block sits beside the execution pipeline's control-register read and write path. The pipeline uses `access_err` to raise its own illegal-access trap. It uses `recheck_pulse` to re-run interrupt selection.

Top module: `priv_ctrl_regs`

Index map (decimal):

| Index | Register |
|---|---|
| 0 | soft-interrupt word |
| 1 | soft-interrupt set alias |
| 2 | soft-interrupt clear alias |
| 3 | trap base |
| 4 | version |
| 5 | hypervisor state |
| 8 to 15 | queue pointers |

All other indices are undefined.

## Requirements
- R1: A write to index 0 stores the data in the soft-interrupt word. A read of index 0, 1 or 2 returns that word.
- R2: A write to index 1 makes the soft-interrupt word equal to its old value OR the written data.
- R3: A write to index 2 makes the soft-interrupt word equal to its old value AND the inverse of the written data.
- R4: The trap base register (index 3) stores the written data with bits 14:0 cleared, and reads of it always return bits 14:0 as zero.
- R5: A read of index 4 returns the constant {40'b0, MAX_GL[7:0], MAX_TL[7:0], NWIN[7:0]}, which is 64'h030608 with default parameters.
- R6: A write to index 4 raises `access_err` during that cycle and leaves every register unchanged.
- R7: Every write to index 5 stores the data with bit 11 forced to 1.
- R8: Each queue pointer (indices 8 to 15) stores its written value and reads it back unchanged.
- R9: A write to a queue pointer drives `recheck_pulse` high for exactly the one cycle after the write edge. Writes to any other index leave it low.
- R10: A read (`rd_en` high) or a write (`wr_en` high) to an undefined index raises `access_err` combinationally. An undefined read returns zero, and an undefined write changes no register.
- R11: After synchronous reset all writable registers read zero and `recheck_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request; qualifies read errors only |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 64 | Combinational read data |
| recheck_pulse | output | 1 | One-cycle interrupt re-evaluation request |
| access_err | output | 1 | Illegal read or write in the current cycle |

## Verification
The checker assumes the write inputs are stable across each rising edge. It also assumes `wr_en` is low during reset, so that no write is pending when the reset is released. The stimulus changes all inputs on the falling edge and holds `wr_en` low while `rst` is high, which keeps both conditions true. The read index is free to move every cycle, because the read-side properties relate only values within the same cycle.

// File: rtl/priv_regs_pkg.sv
package priv_regs_pkg;
  typedef enum logic [2:0] {
    K_SOFT  = 3'd0,
    K_SSET  = 3'd1,
    K_SCLR  = 3'd2,
    K_TBASE = 3'd3,
    K_VER   = 3'd4,
    K_HVST  = 3'd5,
    K_QUEUE = 3'd6,
    K_NONE  = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/priv_idx_decode.sv
module priv_idx_decode
  import priv_regs_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int QUEUE_BASE = 8,
  parameter int NUM_QUEUE  = 8,
  localparam int Q_W       = $clog2(NUM_QUEUE)
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind,
  output logic [Q_W-1:0]   qsel
);
  localparam logic [IDX_W-1:0] Q_LO = IDX_W'(QUEUE_BASE);
  localparam logic [IDX_W-1:0] Q_HI = IDX_W'(QUEUE_BASE + NUM_QUEUE - 1);
  logic [IDX_W-1:0] q_off;

  assign q_off = idx - Q_LO;
  assign qsel  = q_off[Q_W-1:0];

  always_comb begin
    if (idx >= Q_LO && idx <= Q_HI) begin
      kind = K_QUEUE;
    end else begin
      case (idx)
        IDX_W'(0): kind = K_SOFT;
        IDX_W'(1): kind = K_SSET;
        IDX_W'(2): kind = K_SCLR;
        IDX_W'(3): kind = K_TBASE;
        IDX_W'(4): kind = K_VER;
        IDX_W'(5): kind = K_HVST;
        default:   kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/priv_softint_unit.sv
module priv_softint_unit
  import priv_regs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] soft_q
);
  logic [DATA_W-1:0] soft_d;

  always_comb begin
    soft_d = soft_q;
    if (wr_en) begin
      case (wr_kind)
        K_SOFT:  soft_d = wr_data;
        K_SSET:  soft_d = soft_q | wr_data;
        K_SCLR:  soft_d = soft_q & ~wr_data;
        default: soft_d = soft_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) soft_q <= '0;
    else     soft_q <= soft_d;
  end
endmodule

// File: rtl/priv_queue_bank.sv
module priv_queue_bank #(
  parameter int DATA_W    = 64,
  parameter int NUM_QUEUE = 8,
  localparam int Q_W      = $clog2(NUM_QUEUE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [Q_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [Q_W-1:0]    rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              recheck
);
  logic [DATA_W-1:0] ptr_q [NUM_QUEUE];

  for (genvar g = 0; g < NUM_QUEUE; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q[g] <= '0;
      else if (wr_hit && wr_sel == Q_W'(g))
        ptr_q[g] <= wr_data;
    end
  end

  assign rd_data = ptr_q[rd_sel];

  always_ff @(posedge clk) begin
    if (rst) recheck <= 1'b0;
    else     recheck <= wr_hit;
  end
endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
  import priv_regs_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 5,
  parameter int QUEUE_BASE = 8,
  parameter int NUM_QUEUE  = 8,
  parameter int TBASE_ZERO = 15,
  parameter int HV_FORCE   = 11,
  parameter int NWIN       = 8,
  parameter int MAX_TL     = 6,
  parameter int MAX_GL     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              recheck_pulse,
  output logic              access_err
);
  localparam int Q_W = $clog2(NUM_QUEUE);
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'({8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)});
  localparam logic [DATA_W-1:0] TBASE_MASK = ~((DATA_W'(1) << TBASE_ZERO) - DATA_W'(1));
  localparam logic [DATA_W-1:0] HV_BIT     = DATA_W'(1) << HV_FORCE;

  reg_kind_e         wr_kind, rd_kind;
  logic [Q_W-1:0]    wr_qsel, rd_qsel;
  logic [DATA_W-1:0] softint_q, tbase_q, hv_state_q, queue_rd;
  logic              wr_ok;

  priv_idx_decode #(.IDX_W(IDX_W), .QUEUE_BASE(QUEUE_BASE), .NUM_QUEUE(NUM_QUEUE))
    u_wr_dec (.idx(wr_idx), .kind(wr_kind), .qsel(wr_qsel));
  priv_idx_decode #(.IDX_W(IDX_W), .QUEUE_BASE(QUEUE_BASE), .NUM_QUEUE(NUM_QUEUE))
    u_rd_dec (.idx(rd_idx), .kind(rd_kind), .qsel(rd_qsel));

  assign wr_ok = wr_en && wr_kind != K_NONE && wr_kind != K_VER;

  priv_softint_unit #(.DATA_W(DATA_W)) u_soft (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_kind(wr_kind),
    .wr_data(wr_data), .soft_q(softint_q)
  );

  priv_queue_bank #(.DATA_W(DATA_W), .NUM_QUEUE(NUM_QUEUE)) u_queue (
    .clk(clk), .rst(rst), .wr_hit(wr_ok && wr_kind == K_QUEUE),
    .wr_sel(wr_qsel), .wr_data(wr_data), .rd_sel(rd_qsel),
    .rd_data(queue_rd), .recheck(recheck_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tbase_q    <= '0;
      hv_state_q <= '0;
    end else if (wr_ok) begin
      if (wr_kind == K_TBASE) tbase_q    <= wr_data & TBASE_MASK;
      if (wr_kind == K_HVST)  hv_state_q <= wr_data | HV_BIT;
    end
  end

  always_comb begin
    case (rd_kind)
      K_SOFT, K_SSET, K_SCLR: rd_data = softint_q;
      K_TBASE:                rd_data = tbase_q & TBASE_MASK;
      K_VER:                  rd_data = VER_WORD;
      K_HVST:                 rd_data = hv_state_q;
      K_QUEUE:                rd_data = queue_rd;
      default:                rd_data = '0;
    endcase
  end

  assign access_err = (rd_en && rd_kind == K_NONE) ||
                      (wr_en && (wr_kind == K_NONE || wr_kind == K_VER));
endmodule

// File: rtl/priv_ctrl_regs_chk.sv
module priv_ctrl_regs_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              recheck_pulse,
  input logic              access_err,
  input logic [DATA_W-1:0] softint,
  input logic [DATA_W-1:0] hv_state
);
  // R9: a queue pointer write yields the strobe on the next cycle
  assert_recheck_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= IDX_W'(8) && wr_idx <= IDX_W'(15)) |=> recheck_pulse);

  // R9: no strobe without a preceding queue write
  assert_no_recheck_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx >= IDX_W'(8) && wr_idx <= IDX_W'(15)) |=> !recheck_pulse);

  // R7: hypervisor state carries bit 11 after any write to it
  assert_hv_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(5)) |=> hv_state[11]);

  // R2: set alias never drops a bit already present
  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(1)) |=> ((softint & $past(softint)) == $past(softint)));

  // R3: clear alias never introduces a new bit
  assert_clr_only_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(2)) |=> ((softint & ~$past(softint)) == '0));

  // R4: trap base low bits always read zero
  assert_tbase_low_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == IDX_W'(3)) |-> (rd_data[14:0] == 15'd0));

  // R6: version write flagged and leaves soft-interrupt untouched
  assert_ver_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(4)) |-> access_err);
  assert_ver_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(4)) |=> $stable(softint));

  // R10: undefined write flagged
  assert_undef_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == IDX_W'(6) || wr_idx == IDX_W'(7) || wr_idx > IDX_W'(15)))
      |-> access_err);
endmodule

bind priv_ctrl_regs priv_ctrl_regs_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .recheck_pulse(recheck_pulse),
  .access_err(access_err), .softint(softint_q), .hv_state(hv_state_q)
);

// File: tb/tb_priv_ctrl_regs.sv
module tb_priv_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  // entry: {is_write, idx[4:0], data[63:0], expect[63:0], exp_err, req[3:0]}
  localparam logic [138:0] VEC [NV] = '{
    {1'b1, 5'd0,  64'h00F0, 64'h0, 1'b0, 4'd1},                       // R1
    {1'b0, 5'd0,  64'h0, 64'h00F0, 1'b0, 4'd1},                       // R1
    {1'b1, 5'd1,  64'h0F0F, 64'h0, 1'b0, 4'd2},                       // R2
    {1'b0, 5'd0,  64'h0, 64'h0FFF, 1'b0, 4'd2},                       // R2
    {1'b1, 5'd2,  64'h00F1, 64'h0, 1'b0, 4'd3},                       // R3
    {1'b0, 5'd2,  64'h0, 64'h0F0E, 1'b0, 4'd3},                       // R3 alias read
    {1'b1, 5'd3,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 4'd4},        // R4
    {1'b0, 5'd3,  64'h0, 64'hFFFF_FFFF_FFFF_8000, 1'b0, 4'd4},        // R4
    {1'b0, 5'd4,  64'h0, 64'h0003_0608, 1'b0, 4'd5},                  // R5
    {1'b1, 5'd4,  64'h1234, 64'h0, 1'b1, 4'd6},                       // R6
    {1'b0, 5'd4,  64'h0, 64'h0003_0608, 1'b0, 4'd6},                  // R6
    {1'b0, 5'd0,  64'h0, 64'h0F0E, 1'b0, 4'd6},                       // R6 nothing moved
    {1'b1, 5'd5,  64'h0, 64'h0, 1'b0, 4'd7},                          // R7
    {1'b0, 5'd5,  64'h0, 64'h0800, 1'b0, 4'd7},                       // R7
    {1'b1, 5'd5,  64'hF000_0000_0000_0001, 64'h0, 1'b0, 4'd7},        // R7
    {1'b0, 5'd5,  64'h0, 64'hF000_0000_0000_0801, 1'b0, 4'd7},        // R7
    {1'b1, 5'd8,  64'h000A, 64'h0, 1'b0, 4'd8},                       // R8
    {1'b1, 5'd15, 64'h0055, 64'h0, 1'b0, 4'd8},                       // R8
    {1'b0, 5'd8,  64'h0, 64'h000A, 1'b0, 4'd8},                       // R8
    {1'b0, 5'd15, 64'h0, 64'h0055, 1'b0, 4'd8},                       // R8
    {1'b0, 5'd9,  64'h0, 64'h0, 1'b0, 4'd8},                          // R8 untouched
    {1'b0, 5'd20, 64'h0, 64'h0, 1'b1, 4'd10},                         // R10
    {1'b1, 5'd6,  64'hDEAD, 64'h0, 1'b1, 4'd10},                      // R10
    {1'b0, 5'd5,  64'h0, 64'hF000_0000_0000_0801, 1'b0, 4'd10}        // R10 ignored
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic recheck_pulse, access_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  priv_ctrl_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .recheck_pulse(recheck_pulse), .access_err(access_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [63:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    rd_idx = 5'd0; #1 check("R11 softint", rd_data, 64'h0);
    rd_idx = 5'd5; #1 check("R11 hvstate", rd_data, 64'h0);
    rd_idx = 5'd12; #1 check("R11 queue", rd_data, 64'h0);
    check("R11 recheck", {63'h0, recheck_pulse}, 64'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      if (VEC[i][138]) begin
        wr_en = 1'b1; wr_idx = VEC[i][137:133]; wr_data = VEC[i][132:69];
        #1 check({rq, " err"}, {63'h0, access_err}, {63'h0, VEC[i][4]});
        @(negedge clk);
        wr_en = 1'b0;
      end else begin
        rd_en = 1'b1; rd_idx = VEC[i][137:133];
        #1 check({rq, " data"}, rd_data, VEC[i][68:5]);
        check({rq, " err"}, {63'h0, access_err}, {63'h0, VEC[i][4]});
        @(negedge clk);
        rd_en = 1'b0;
      end
    end

    // R9: strobe exactly one cycle after a queue write
    do_write(5'd11, 64'h77);
    check("R9 pulse high", {63'h0, recheck_pulse}, 64'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {63'h0, recheck_pulse}, 64'h0);
    do_write(5'd0, 64'h1);
    check("R9 no pulse other idx", {63'h0, recheck_pulse}, 64'h0);
    do_write(5'd4, 64'h5);
    check("R9 no pulse version write", {63'h0, recheck_pulse}, 64'h0);
    // R10: read error needs rd_en
    rd_en = 1'b0; rd_idx = 5'd31; #1
    check("R10 no err without rd_en", {63'h0, access_err}, 64'h0);
    // R11: reset clears after activity
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd_idx = 5'd11; #1 check("R11 queue after reset", rd_data, 64'h0);
    rd_idx = 5'd3;  #1 check("R11 tbase after reset", rd_data, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule